// File: doc/BRIEF.md
# DMA Page Register Unit

This unit holds the upper address bits for two DMA controllers that share an I/O window: a byte controller with four channels and a word controller with four channels. Software writes a page byte at one of sixteen byte offsets. The unit keeps every written byte, untruncated, for readback. When the offset belongs to a channel, the unit merges the page into bits [23:16] of that channel's base address and its current address.

The unit also holds the low address bytes of every channel and exposes them through a byte-load port. Byte channels take the low and high bytes directly. Word channels keep their addresses as byte addresses shifted left by one, so each loaded byte lands one bit higher and bit 0 of the page is never kept. A step port advances the current address the way a transfer engine would: one byte for byte channels and two bytes for word channels. Each step wraps inside the channel's own window.

A view port selects one channel and shows its full base address, its full current address, and the low or high programming byte of its current address in the channel's own format.

Top module: `dma_page_unit`

## Requirements
- R1: After reset every stored page byte reads 0, and every channel's base and current address is 0.
- R2: A page write at any offset 0..15 stores the full 8-bit value. A later read at that offset returns it unchanged, whatever the channel mapping or mode.
- R3: Page offsets map to channels as follows. Byte channels: offset 7 is channel 0, offset 3 is channel 1, offset 1 is channel 2 and offset 2 is channel 3. Word channels: offset 15 is channel 0, offset 11 is channel 1, offset 9 is channel 2 and offset 10 is channel 3. A write at any other offset changes no address.
- R4: For a byte channel, `at_mode`=1 places all 8 page bits in address [23:16]. With `at_mode`=0 only page bits [3:0] are kept, and address [23:20] becomes 0.
- R5: For a word channel, a page write sets address [23:17] to page bits [7:1]. Page bit 0 is dropped, and address [16:0] is kept.
- R6: A page write updates the base address and the current address of the mapped channel together, and leaves the lower address bits of both as they were.
- R7: A byte-load with `ld_hi`=0 writes address [7:0] of a byte channel or [8:1] of a word channel. With `ld_hi`=1 it writes [15:8] or [16:9]. The load goes to base and current, and all other bits are kept.
- R8: `vw_byte` returns the current-address field that R7 loads for the selected channel and half.
- R9: A word-channel step adds 2 (`st_down`=0) or subtracts 2 (`st_down`=1) modulo 2^17 on current address [16:0]. Bits [23:17] and the base address stay unchanged.
- R10: A byte-channel step adds or subtracts 1 modulo 2^16 on current address [15:0]. Bits [23:16] and the base address stay unchanged.
- R11: When a step, a byte-load and a page write hit the same channel in one cycle, they apply in that order, and a later one overwrites the bits it owns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| at_mode | input | 1 | 1: byte-channel pages keep 8 bits; 0: 4 bits |
| pg_we | input | 1 | Page write strobe |
| pg_ofs | input | 4 | Page offset for write and readback |
| pg_wdata | input | 8 | Page byte to write |
| pg_rdata | output | 8 | Stored byte at `pg_ofs` |
| ld_we | input | 1 | Address byte-load strobe |
| ld_word | input | 1 | 1: word controller, 0: byte controller |
| ld_chan | input | 2 | Channel of the byte-load |
| ld_hi | input | 1 | 1: high byte, 0: low byte |
| ld_data | input | 8 | Address byte to load |
| st_en | input | 1 | Step strobe for the current address |
| st_word | input | 1 | Controller of the step |
| st_chan | input | 2 | Channel of the step |
| st_down | input | 1 | 1: decrement, 0: increment |
| vw_word | input | 1 | Controller selected for view |
| vw_chan | input | 2 | Channel selected for view |
| vw_hi | input | 1 | Half selected for `vw_byte` |
| vw_byte | output | 8 | Programming byte of the selected current address |
| vw_base | output | 24 | Base address of the selected channel |
| vw_cur | output | 24 | Current address of the selected channel |

## Verification
A wrong offset decode or a wrong truncation mask puts bad bits into the base and current page of a channel. These show on `vw_base` and `vw_cur` in the cycle after the write. A misplaced shift on a word channel shows at once on `vw_byte` as a byte read back one bit off. A wrong wrap width only shows when a step crosses a 16- or 17-bit boundary, so the bench drives those crossings on purpose. Because a bad value persists in the registers, every later view of the same channel shows it again.

// File: rtl/dma_pg_pkg.sv
package dma_pg_pkg;
  localparam int AW    = 24;
  localparam int PG_LO = 16;
  localparam int NCH   = 4;
  localparam int CW    = $clog2(NCH);
  localparam int NTOT  = 2 * NCH;
  localparam int OFS_W = 4;
  localparam int NOFS  = 1 << OFS_W;

  typedef struct packed {
    logic          hit;
    logic          word;
    logic [CW-1:0] chan;
  } pg_map_t;

  // offset bit 3 selects the controller, bits [2:0] the channel
  function automatic pg_map_t map_ofs(input logic [OFS_W-1:0] o);
    pg_map_t m;
    m.word = o[3];
    m.hit  = 1'b1;
    case (o[2:0])
      3'd7:    m.chan = CW'(0);
      3'd3:    m.chan = CW'(1);
      3'd1:    m.chan = CW'(2);
      3'd2:    m.chan = CW'(3);
      default: begin m.chan = '0; m.hit = 1'b0; end
    endcase
    return m;
  endfunction

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a,
                                              input logic word, input logic down);
    logic [16:0] w;
    logic [15:0] b;
    w = a[16:0] + (down ? 17'h1FFFE : 17'h00002);
    b = a[15:0] + (down ? 16'hFFFF : 16'h0001);
    return word ? {a[AW-1:17], w} : {a[AW-1:16], b};
  endfunction

  function automatic logic [AW-1:0] load_byte(input logic [AW-1:0] a, input logic word,
                                              input logic hi, input logic [7:0] v);
    logic [AW-1:0] r;
    r = a;
    case ({word, hi})
      2'b00: r[7:0]  = v;
      2'b01: r[15:8] = v;
      2'b10: r[8:1]  = v;
      default: r[16:9] = v;
    endcase
    return r;
  endfunction

  function automatic logic [AW-1:0] merge_page(input logic [AW-1:0] a, input logic word,
                                               input logic at, input logic [7:0] v);
    if (word) return {v[7:1], a[16:0]};
    return {(at ? v : {4'h0, v[3:0]}), a[PG_LO-1:0]};
  endfunction

  function automatic logic [7:0] view_byte(input logic [AW-1:0] a, input logic word,
                                           input logic hi);
    case ({word, hi})
      2'b00: return a[7:0];
      2'b01: return a[15:8];
      2'b10: return a[8:1];
      default: return a[16:9];
    endcase
  endfunction
endpackage

// File: rtl/dma_pg_decode.sv
module dma_pg_decode
  import dma_pg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [OFS_W-1:0] ofs,
  output logic [NTOT-1:0]  hit
);
  pg_map_t m;
  assign m = map_ofs(ofs);

  for (genvar g = 0; g < NTOT; g++) begin : g_hit
    localparam logic          GW = (g >= NCH);
    localparam logic [CW-1:0] GC = CW'(g % NCH);
    assign hit[g] = we && m.hit && (m.word == GW) && (m.chan == GC);
  end

  // R3
  map_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit));
endmodule

// File: rtl/dma_pg_bytefile.sv
module dma_pg_bytefile
  import dma_pg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [OFS_W-1:0] ofs,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata
);
  logic [7:0] mem [NOFS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NOFS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[ofs] <= wdata;
    end
  end

  assign rdata = mem[ofs];

  // R2
  raw_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(ofs)] == $past(wdata));
endmodule

// File: rtl/dma_pg_chan.sv
module dma_pg_chan
  import dma_pg_pkg::*;
#(
  parameter bit IS_WORD = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          at_mode,
  input  logic          pg_hit,
  input  logic [7:0]    pg_val,
  input  logic          ld_hit,
  input  logic          ld_hi,
  input  logic [7:0]    ld_val,
  input  logic          st_hit,
  input  logic          st_down,
  output logic [AW-1:0] base,
  output logic [AW-1:0] cur
);
  logic [AW-1:0] cur_s, cur_l, cur_n, base_l, base_n;

  // step first, then byte-load, then page (R11)
  assign cur_s  = st_hit ? step_addr(cur, IS_WORD, st_down) : cur;
  assign cur_l  = ld_hit ? load_byte(cur_s, IS_WORD, ld_hi, ld_val) : cur_s;
  assign cur_n  = pg_hit ? merge_page(cur_l, IS_WORD, at_mode, pg_val) : cur_l;
  assign base_l = ld_hit ? load_byte(base, IS_WORD, ld_hi, ld_val) : base;
  assign base_n = pg_hit ? merge_page(base_l, IS_WORD, at_mode, pg_val) : base_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base <= '0;
      cur  <= '0;
    end else begin
      base <= base_n;
      cur  <= cur_n;
    end
  end

  // R6
  page_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pg_hit |=> base[AW-1:17] == cur[AW-1:17]);
  // R4
  short_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pg_hit && !IS_WORD && !at_mode |=> cur[AW-1:20] == '0);
  // R5
  word_page_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pg_hit && IS_WORD && !st_hit && !ld_hit |=> cur[16:0] == $past(cur[16:0]));
  // R9
  step_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_hit && !ld_hit && !pg_hit |=> $stable(base) && cur[AW-1:17] == $past(cur[AW-1:17]));
endmodule

// File: rtl/dma_page_unit.sv
module dma_page_unit
  import dma_pg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        at_mode,
  input  logic        pg_we,
  input  logic [3:0]  pg_ofs,
  input  logic [7:0]  pg_wdata,
  output logic [7:0]  pg_rdata,
  input  logic        ld_we,
  input  logic        ld_word,
  input  logic [1:0]  ld_chan,
  input  logic        ld_hi,
  input  logic [7:0]  ld_data,
  input  logic        st_en,
  input  logic        st_word,
  input  logic [1:0]  st_chan,
  input  logic        st_down,
  input  logic        vw_word,
  input  logic [1:0]  vw_chan,
  input  logic        vw_hi,
  output logic [7:0]  vw_byte,
  output logic [23:0] vw_base,
  output logic [23:0] vw_cur
);
  logic [NTOT-1:0] pg_hit;
  logic [AW-1:0]   base_a [NTOT];
  logic [AW-1:0]   cur_a  [NTOT];
  logic [CW:0]     vw_idx;

  dma_pg_decode u_dec (
    .clk(clk), .rst_n(rst_n), .we(pg_we), .ofs(pg_ofs), .hit(pg_hit)
  );

  dma_pg_bytefile u_raw (
    .clk(clk), .rst_n(rst_n), .we(pg_we), .ofs(pg_ofs),
    .wdata(pg_wdata), .rdata(pg_rdata)
  );

  for (genvar g = 0; g < NTOT; g++) begin : g_ch
    localparam bit            GW = (g >= NCH);
    localparam logic [CW-1:0] GC = CW'(g % NCH);
    logic ld_hit, st_hit;
    assign ld_hit = ld_we && (ld_word == GW) && (ld_chan == GC);
    assign st_hit = st_en && (st_word == GW) && (st_chan == GC);
    dma_pg_chan #(.IS_WORD(GW)) u_ch (
      .clk(clk), .rst_n(rst_n), .at_mode(at_mode),
      .pg_hit(pg_hit[g]), .pg_val(pg_wdata),
      .ld_hit(ld_hit), .ld_hi(ld_hi), .ld_val(ld_data),
      .st_hit(st_hit), .st_down(st_down),
      .base(base_a[g]), .cur(cur_a[g])
    );
  end

  assign vw_idx  = {vw_word, vw_chan};
  assign vw_base = base_a[vw_idx];
  assign vw_cur  = cur_a[vw_idx];
  assign vw_byte = view_byte(cur_a[vw_idx], vw_word, vw_hi);
endmodule

// File: tb/dma_page_unit_test.sv
module dma_page_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic at_mode = 1'b0;
  logic pg_we = 1'b0;
  logic [3:0] pg_ofs = '0;
  logic [7:0] pg_wdata = '0;
  logic [7:0] pg_rdata;
  logic ld_we = 1'b0, ld_word = 1'b0, ld_hi = 1'b0;
  logic [1:0] ld_chan = '0;
  logic [7:0] ld_data = '0;
  logic st_en = 1'b0, st_word = 1'b0, st_down = 1'b0;
  logic [1:0] st_chan = '0;
  logic vw_word = 1'b0, vw_hi = 1'b0;
  logic [1:0] vw_chan = '0;
  logic [7:0] vw_byte;
  logic [23:0] vw_base, vw_cur;

  int n_chk = 0, n_bad = 0;
  logic [23:0] mb [8];
  logic [23:0] mc [8];
  logic [7:0]  mraw [16];
  int ofs_tab [8] = '{7, 3, 1, 2, 15, 11, 9, 10};

  always #5 clk = ~clk;

  dma_page_unit uut (.*);

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  function automatic int ofs_idx(input int o);
    for (int k = 0; k < 8; k++) if (ofs_tab[k] == o) return k;
    return -1;
  endfunction

  function automatic logic [23:0] m_step(input logic [23:0] a, input bit w, input bit d);
    int unsigned span = w ? 32'h20000 : 32'h10000;
    int unsigned inc  = w ? 2 : 1;
    int unsigned lo   = a % span;
    lo = d ? (lo + span - inc) % span : (lo + inc) % span;
    return (a - 24'(a % span)) + 24'(lo);
  endfunction

  function automatic logic [23:0] m_load(input logic [23:0] a, input bit w, input bit h,
                                         input logic [7:0] v);
    int sh = (w ? 1 : 0) + (h ? 8 : 0);
    return (a & ~(24'hFF << sh)) | (24'(v) << sh);
  endfunction

  function automatic logic [23:0] m_page(input logic [23:0] a, input bit w, input bit at,
                                         input logic [7:0] v);
    if (w) return (a & 24'h01FFFF) | (24'(v & 8'hFE) << 16);
    return (a & 24'h00FFFF) | (24'(at ? v : (v & 8'h0F)) << 16);
  endfunction

  function automatic logic [7:0] m_view(input logic [23:0] a, input bit w, input bit h);
    return 8'((a >> ((w ? 1 : 0) + (h ? 8 : 0))) & 24'hFF);
  endfunction

  task automatic chk(input string tag, input logic [23:0] got, input logic [23:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic op(input bit pw, input int po, input logic [7:0] pv,
                    input bit lw, input bit lwd, input int lc, input bit lh, input logic [7:0] lv,
                    input bit sw, input bit swd, input int sc, input bit sd);
    int pi;
    pg_we = pw; pg_ofs = 4'(po); pg_wdata = pv;
    ld_we = lw; ld_word = lwd; ld_chan = 2'(lc); ld_hi = lh; ld_data = lv;
    st_en = sw; st_word = swd; st_chan = 2'(sc); st_down = sd;
    @(posedge clk);
    if (sw) mc[sc + (swd ? 4 : 0)] = m_step(mc[sc + (swd ? 4 : 0)], swd, sd);
    if (lw) begin
      mc[lc + (lwd ? 4 : 0)] = m_load(mc[lc + (lwd ? 4 : 0)], lwd, lh, lv);
      mb[lc + (lwd ? 4 : 0)] = m_load(mb[lc + (lwd ? 4 : 0)], lwd, lh, lv);
    end
    if (pw) begin
      mraw[po] = pv;
      pi = ofs_idx(po);
      if (pi >= 0) begin
        mc[pi] = m_page(mc[pi], pi >= 4, at_mode, pv);
        mb[pi] = m_page(mb[pi], pi >= 4, at_mode, pv);
      end
    end
    #2;
    pg_we = 1'b0; ld_we = 1'b0; st_en = 1'b0;
  endtask

  task automatic look(input int idx, input string tag);
    vw_word = (idx >= 4); vw_chan = 2'(idx % 4); vw_hi = 1'b0;
    #1;
    chk({tag, " base"}, vw_base, mb[idx]);
    chk({tag, " cur"}, vw_cur, mc[idx]);
    chk({tag, " lo byte"}, 24'(vw_byte), 24'(m_view(mc[idx], idx >= 4, 1'b0)));
    vw_hi = 1'b1;
    #1;
    chk({tag, " hi byte"}, 24'(vw_byte), 24'(m_view(mc[idx], idx >= 4, 1'b1)));
  endtask

  task automatic raw(input int o, input string tag);
    pg_ofs = 4'(o);
    #1;
    chk(tag, 24'(pg_rdata), 24'(mraw[o]));
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) begin mb[i] = '0; mc[i] = '0; end
    for (int i = 0; i < 16; i++) mraw[i] = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1 reset state
    for (int i = 0; i < 8; i++) look(i, "R1 reset chan");
    for (int i = 0; i < 16; i++) raw(i, "R1 reset raw");

    // R3 mapping, byte channels with AT pages
    at_mode = 1'b1;
    for (int k = 0; k < 8; k++) begin
      op(1, ofs_tab[k], 8'(8'hA1 + k * 8'h11), 0, 0, 0, 0, 0, 0, 0, 0, 0);
      for (int j = 0; j < 8; j++) look(j, "R3 map");
    end
    // R3 unmapped offsets touch no address
    op(1, 0, 8'hEE, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    op(1, 12, 8'h77, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int j = 0; j < 8; j++) look(j, "R3 unmapped");
    raw(0, "R2 raw unmapped"); raw(12, "R2 raw unmapped");

    // R4 non-AT truncation, raw byte kept whole
    at_mode = 1'b0;
    op(1, 7, 8'hFB, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    look(0, "R4 short page");
    raw(7, "R2 raw full byte");
    at_mode = 1'b1;
    op(1, 3, 8'hC6, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    look(1, "R4 full page");

    // R7 R8 word byte loads, R5 odd page drops bit 0
    op(0, 0, 0, 1, 1, 2, 0, 8'hFF, 0, 0, 0, 0);
    op(0, 0, 0, 1, 1, 2, 1, 8'h81, 0, 0, 0, 0);
    look(6, "R7 R8 word load");
    op(1, 9, 8'h35, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    look(6, "R5 R6 word page");
    op(0, 0, 0, 1, 0, 3, 1, 8'h5A, 0, 0, 0, 0);
    look(3, "R7 byte load");

    // R9 word step wrap both ways
    op(0, 0, 0, 1, 1, 0, 0, 8'hFF, 0, 0, 0, 0);
    op(0, 0, 0, 1, 1, 0, 1, 8'hFF, 0, 0, 0, 0);
    op(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0);
    look(4, "R9 word wrap up");
    op(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 1);
    look(4, "R9 word wrap down");
    // R10 byte step wrap down from 0 low half
    op(0, 0, 0, 1, 0, 2, 0, 8'h00, 0, 0, 0, 0);
    op(0, 0, 0, 1, 0, 2, 1, 8'h00, 0, 0, 0, 0);
    op(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 2, 1);
    look(2, "R10 byte wrap down");
    op(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 2, 0);
    look(2, "R10 byte wrap up");

    // R11 same-cycle ordering
    op(1, 11, 8'h9C, 1, 1, 1, 1, 8'h44, 1, 1, 1, 1);
    look(5, "R11 order word");
    op(1, 1, 8'h3D, 1, 0, 2, 0, 8'h10, 1, 0, 2, 0);
    look(2, "R11 order byte");

    // random mix
    for (int n = 0; n < 600; n++) begin
      int po, lc, sc, pi;
      bit pw, lw, sw, lwd, swd;
      if ($urandom % 16 == 0) at_mode = ~at_mode;
      pw = ($urandom % 2) == 0; po = $urandom % 16;
      lw = ($urandom % 3) == 0; lwd = $urandom % 2; lc = $urandom % 4;
      sw = ($urandom % 3) == 0; swd = $urandom % 2; sc = $urandom % 4;
      op(pw, po, 8'($urandom), lw, lwd, lc, 1'($urandom), 8'($urandom),
         sw, swd, sc, 1'($urandom));
      pi = ofs_idx(po);
      look((pw && pi >= 0) ? pi : (lw ? lc + (lwd ? 4 : 0) : $urandom % 8), "R11 random");
      raw(po, "R2 random raw");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule